// File: doc/BRIEF.md
# Register-Mapped Reset Line Controller

This block drives a vector of reset lines for other blocks on a chip, under software control through a small word-addressed register interface. The lines are grouped 32 to a register. Each group is reachable through two registers: a pulse register, where writing a 1 to a bit fires a self-clearing reset pulse of fixed length on that line, and a level register, which holds the line in reset for as long as its bit is 0. A line's output is asserted while its pulse runs or while its level bit is cleared.

Software uses the pulse registers for a quick reset. A write only needs the 1 bits of the lines it wants to reset, so no read-modify-write is needed. Software uses the level registers to keep a block in reset across a longer sequence. Level registers read back what was written, so single bits can be changed by read-modify-write. Pulse registers read back the pulses still running.

The interface uses plain strobes and carries no valid/ready flow. A write completes on the clock edge where `wr_en` is sampled high. A read sampled on an edge returns its data on `rd_data` with `rd_valid` high in the following cycle. Neither side can apply back-pressure. `LEVEL_BASE` must be word-aligned and must lie at or above `4*NUM_REGS`. `ADDR_W` must be wide enough to reach `LEVEL_BASE + 4*NUM_REGS`.

Top module: `rstc_top`

## Requirements
- R1: After `rst_n` is released, every level register reads 0xFFFFFFFF, every pulse register reads 0, and every bit of `rst_out` is 0.
- R2: Line id maps to register index id/32 and bit id%32. Pulse register n sits at byte address 4n. Level register n sits at byte address `LEVEL_BASE`+4n.
- R3: When a write to a pulse register has a bit set to 1, the matching line is asserted for exactly `PULSE_CYCLES` cycles. The pulse starts in the cycle after the write edge, and the line then clears by itself.
- R4: A 0 bit in a pulse-register write has no effect on that line, whether its pulse is idle or running.
- R5: Writing 1 to a line whose pulse is still running restarts the pulse at its full length of `PULSE_CYCLES` cycles from that write.
- R6: A read of a pulse register returns the pulses that are active at the read edge, one bit per line.
- R7: A level bit of 0 holds its line asserted and a level bit of 1 releases it, starting the cycle after the write. A read of a level register returns the last value written.
- R8: `rst_out` for a line is 1 when its pulse is active or when its level bit is 0. A pulse that ends does not release a line whose level bit is 0.
- R9: An address that is not word-aligned, falls in the gap between the banks, or lies beyond the level bank reads as 0, and a write to it changes no register and no output.
- R10: `rd_valid` is high in exactly the cycle after each edge where `rd_en` is sampled high, and `rd_data` holds the read result in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per sampled edge |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | High the cycle after a sampled read |
| rst_out | output | 32*NUM_REGS | Reset lines, 1 = line held in reset |

## Verification
The bench builds the block with its defaults: eight registers per bank, the level bank at 0x7C, and four-cycle pulses. These values put lines 0 through 255 within reach, including line 255 in the top register of both banks. They also leave a wide unmapped gap from 0x20 to 0x78 and a region beyond 0x98, both of which are probed. With a four-cycle pulse, the bench can place a restart write and a zero-bit write inside a running pulse, and can tell a restarted end cycle apart from the original one.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int LINES_PER_REG = 32;

  typedef logic [LINES_PER_REG-1:0] word_t;

  typedef enum logic [1:0] {
    HIT_NONE  = 2'd0,
    HIT_PULSE = 2'd1,
    HIT_LEVEL = 2'd2
  } hit_e;
endpackage

// File: rtl/rstc_addr_decode.sv
module rstc_addr_decode
  import rstc_pkg::*;
#(
  parameter int NUM_REGS   = 8,
  parameter int LEVEL_BASE = 'h7C,
  parameter int ADDR_W     = 8,
  parameter int IDX_W      = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_e              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [31:0] PULSE_END = 32'(NUM_REGS);
  localparam logic [31:0] LVL_LO    = 32'(LEVEL_BASE / 4);
  localparam logic [31:0] LVL_END   = LVL_LO + 32'(NUM_REGS);

  logic [31:0] word_no;

  always_comb begin
    word_no = 32'(addr >> 2);
    hit     = HIT_NONE;
    idx     = '0;
    if (addr[1:0] == 2'b00) begin
      if (word_no < PULSE_END) begin
        hit = HIT_PULSE;
        idx = IDX_W'(word_no);
      end else if (word_no >= LVL_LO && word_no < LVL_END) begin
        hit = HIT_LEVEL;
        idx = IDX_W'(word_no - LVL_LO);
      end
    end
  end
endmodule

// File: rtl/rstc_pulse_lane.sv
module rstc_pulse_lane #(
  parameter int PULSE_CYCLES = 4,
  parameter int CNT_W        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (fire)            cnt_q <= CNT_W'(PULSE_CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);

  // R3 and R5: a fire loads the full length, also while running
  assert_pulse_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == CNT_W'(PULSE_CYCLES)));

  // R3: a running pulse counts down by one per cycle
  assert_pulse_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R4: an idle lane stays idle without a fire
  assert_pulse_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !active) |=> !active);
endmodule

// File: rtl/rstc_pulse_bank.sv
module rstc_pulse_bank
  import rstc_pkg::*;
#(
  parameter int NUM_REGS     = 8,
  parameter int PULSE_CYCLES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_REGS-1:0]      wr_sel,
  input  word_t                    wr_data,
  output logic [NUM_REGS-1:0][31:0] active
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar b = 0; b < LINES_PER_REG; b++) begin : g_line
      rstc_pulse_lane #(
        .PULSE_CYCLES(PULSE_CYCLES),
        .CNT_W       (CNT_W)
      ) u_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (wr_sel[r] & wr_data[b]),
        .active(active[r][b])
      );
    end
  end

  // R2: at most one pulse register is written per cycle
  assert_pulse_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));
endmodule

// File: rtl/rstc_level_bank.sv
module rstc_level_bank
  import rstc_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REGS-1:0]       wr_sel,
  input  word_t                     wr_data,
  output logic [NUM_REGS-1:0][31:0] level_q
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         level_q[r] <= '1;
      else if (wr_sel[r]) level_q[r] <= wr_data;
    end
  end

  // R2: at most one level register is written per cycle
  assert_level_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

  // R7: level registers change only when written
  assert_level_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|wr_sel) |=> $stable(level_q));
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int NUM_REGS     = 8,
  parameter int LEVEL_BASE   = 'h7C,
  parameter int PULSE_CYCLES = 4,
  parameter int ADDR_W       = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [31:0]                  wr_data,
  output logic [31:0]                  rd_data,
  output logic                         rd_valid,
  output logic [NUM_REGS*32-1:0]       rst_out
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  hit_e                      hit;
  logic [IDX_W-1:0]          idx;
  logic [NUM_REGS-1:0]       pulse_sel;
  logic [NUM_REGS-1:0]       level_sel;
  logic [NUM_REGS-1:0][31:0] pulse_act;
  logic [NUM_REGS-1:0][31:0] level_q;

  rstc_addr_decode #(
    .NUM_REGS  (NUM_REGS),
    .LEVEL_BASE(LEVEL_BASE),
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W)
  ) u_dec (
    .addr(addr),
    .hit (hit),
    .idx (idx)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
    assign pulse_sel[r] = wr_en && (hit == HIT_PULSE) && (idx == IDX_W'(r));
    assign level_sel[r] = wr_en && (hit == HIT_LEVEL) && (idx == IDX_W'(r));
  end

  rstc_pulse_bank #(
    .NUM_REGS    (NUM_REGS),
    .PULSE_CYCLES(PULSE_CYCLES)
  ) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_sel (pulse_sel),
    .wr_data(wr_data),
    .active (pulse_act)
  );

  rstc_level_bank #(
    .NUM_REGS(NUM_REGS)
  ) u_level (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_sel (level_sel),
    .wr_data(wr_data),
    .level_q(level_q)
  );

  // read port: one cycle of latency, unmapped reads return zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        unique case (hit)
          HIT_PULSE: rd_data <= pulse_act[idx];
          HIT_LEVEL: rd_data <= level_q[idx];
          default:   rd_data <= '0;
        endcase
      end
    end
  end

  // a line is in reset while its pulse runs or its level bit is low
  assign rst_out = pulse_act | ~level_q;

  // R10: valid follows each sampled read by one cycle
  assert_rd_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_rd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R9: unmapped reads return zero, unmapped writes leave the levels alone
  assert_unmapped_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit == HIT_NONE) |=> (rd_data == '0));
  assert_unmapped_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit == HIT_NONE) |=> $stable(level_q));

  // R8: a line with a cleared level bit is always in reset
  assert_level_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (~level_q & ~rst_out) == '0);
endmodule

// File: tb/tb_rstc_top.sv
module tb_rstc_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINES      = 256;

  typedef struct packed {
    logic        is_wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] expect_v;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h7C, 32'h0,         32'hFFFF_FFFF, 4'd1},  // R1 level reg 0
    '{1'b0, 8'h98, 32'h0,         32'hFFFF_FFFF, 4'd1},  // R1 level reg 7
    '{1'b0, 8'h00, 32'h0,         32'h0,         4'd6},  // R6 no pulses
    '{1'b0, 8'h1C, 32'h0,         32'h0,         4'd6},  // R6 top pulse reg
    '{1'b1, 8'h7C, 32'hA5A5_A5A5, 32'h0,         4'd7},  // R7 write
    '{1'b0, 8'h7C, 32'h0,         32'hA5A5_A5A5, 4'd7},  // R7 read back
    '{1'b1, 8'h7C, 32'hFFFF_FFFF, 32'h0,         4'd7},  // R7 restore
    '{1'b0, 8'h7C, 32'h0,         32'hFFFF_FFFF, 4'd7},  // R7 read back
    '{1'b1, 8'h20, 32'hFFFF_FFFF, 32'h0,         4'd9},  // R9 gap write
    '{1'b0, 8'h20, 32'h0,         32'h0,         4'd9},  // R9 gap read
    '{1'b0, 8'h9C, 32'h0,         32'h0,         4'd9},  // R9 beyond level bank
    '{1'b0, 8'h7E, 32'h0,         32'h0,         4'd9}   // R9 misaligned
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic             rd_en = 1'b0;
  logic [7:0]       addr = '0;
  logic [31:0]      wr_data = '0;
  logic [31:0]      rd_data;
  logic             rd_valid;
  logic [LINES-1:0] rst_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstc_top dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .rd_valid(rd_valid),
    .rst_out (rst_out)
  );

  function automatic logic [LINES-1:0] line_bit(input int id);
    return {{(LINES-1){1'b0}}, 1'b1} << id;
  endfunction

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic chkvec(input string req, input logic [LINES-1:0] exp_v);
    checks++;
    if (rst_out !== exp_v) begin
      fails++;
      $display("FAIL %s: actual rst_out %h expected %h", req, rst_out, exp_v);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
    chk32("R10 rd_valid", {31'b0, rd_valid}, 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chkvec("R1 reset outputs", '0);
    chk32("R10 idle rd_valid", {31'b0, rd_valid}, 32'h0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].is_wr) begin
        bus_write(VECS[i].addr, VECS[i].data);
      end else begin
        bus_read(VECS[i].addr, d);
        chk32($sformatf("R%0d vector %0d", VECS[i].req, i), d, VECS[i].expect_v);
      end
    end
    chkvec("R9 gap write left outputs", '0);

    // R3 / R6: pulse on line 35, read back while running
    bus_write(8'h04, 32'h8);
    chkvec("R3 pulse cycle 1", line_bit(35));
    rd_en = 1'b1; addr = 8'h04;
    @(negedge clk);
    rd_en = 1'b0;
    chk32("R6 pulse readback", rd_data, 32'h8);
    chkvec("R3 pulse cycle 2", line_bit(35));
    @(negedge clk);
    @(negedge clk);
    chkvec("R3 pulse cycle 4", line_bit(35));
    @(negedge clk);
    chkvec("R3 pulse ended", '0);

    // R5: restart two cycles into the pulse
    bus_write(8'h04, 32'h8);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h04; wr_data = 32'h8;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chkvec("R5 restarted pulse still on", line_bit(35));
    @(negedge clk);
    chkvec("R5 restarted pulse ended", '0);

    // R4: a zero bit for line 35 does not disturb it; line 32 fires (R2)
    bus_write(8'h04, 32'h8);
    wr_en = 1'b1; addr = 8'h04; wr_data = 32'h1;
    @(negedge clk);
    wr_en = 1'b0;
    chkvec("R4 R2 both running", line_bit(35) | line_bit(32));
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chkvec("R4 line 35 ends on time", line_bit(32));
    @(negedge clk);
    chkvec("R4 line 32 ended", '0);
    bus_write(8'h1C, 32'h0);
    chkvec("R4 all-zero pulse write", '0);

    // R7 / R2: level bit 5 of register 1 holds line 37
    bus_write(8'h80, 32'hFFFF_FFDF);
    chkvec("R7 level hold line 37", line_bit(37));
    bus_read(8'h80, d);
    chk32("R7 level readback", d, 32'hFFFF_FFDF);

    // R8: pulse on the same line does not release it when it ends
    bus_write(8'h04, 32'h20);
    chkvec("R8 pulse and level", line_bit(37));
    repeat (5) @(negedge clk);
    chkvec("R8 level keeps line after pulse", line_bit(37));
    bus_write(8'h80, 32'hFFFF_FFFF);
    chkvec("R7 level release", '0);

    // R2: top line through both banks
    bus_write(8'h98, 32'h7FFF_FFFF);
    chkvec("R2 level line 255", line_bit(255));
    bus_write(8'h98, 32'hFFFF_FFFF);
    bus_write(8'h1C, 32'h8000_0000);
    chkvec("R2 pulse line 255", line_bit(255));
    repeat (4) @(negedge clk);
    chkvec("R3 line 255 ended", '0);

    // R9: ignored writes at unmapped addresses
    bus_write(8'h7D, 32'h0);
    bus_write(8'h9C, 32'h0);
    bus_write(8'h78, 32'h0);
    chkvec("R9 unmapped writes", '0);
    bus_read(8'h7C, d);
    chk32("R9 level reg 0 untouched", d, 32'hFFFF_FFFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule